// File: doc/BRIEF.md
# Buffered-Compare PWM Timer

This block is an up-counting pulse-width timer with two compare values. Compare A marks the point in the period where the output turns active. Compare B marks the last count of the period, and the counter then starts again from zero. Software sets it up through a small word-wide register bus. The bus has four locations: control, compare A, compare B, and a read-only view of the counter.

The counter advances on count ticks. A tick is either a one-cycle enable from an internal prescaler, or a rising edge on an external clock pin. The external pin is brought into the system clock domain before it is used. The compare values can be double-buffered. In that case software writes a shadow copy, and the shadow is copied into the working compare values only at a period boundary or on a software counter reset. A fine mode lets the active edge of the output move by half a system clock cycle. Separate controls set the output polarity, gate the output to an idle level, and choose the level the output starts from.

Top module: `pwm_timer`

## Requirements
- R1: Bus addresses are 0 = control, 1 = compare A, 2 = compare B, 3 = counter (read-only). In the control word, bit 0 = run, bit 1 = software reset, bit 2 = output enable, bit 3 = external clock select, bit 4 = invert, bit 5 = buffer enable, bit 6 = fine mode, bit 8 = initial level. All register bits are 0 after reset. Control bits 1, 7 and 9-15 always read 0.
- R2: Writing the control word with bit 1 set clears the counter to 0 in the next cycle and loads the initial level into the output state. Writing the control word with bit 1 clear leaves the counter unchanged.
- R3: While run is 1, each count tick adds 1 to the counter. A tick taken while the counter equals compare B reloads the counter to 0 instead, so one period is B+1 ticks. While run is 0 the counter holds its value.
- R4: The output state goes active after a tick taken at count = A, and goes off after a tick taken at count = B. B wins when A = B. When A is greater than or equal to B, the output never turns active.
- R5: When output enable is 1, the pin equals the output state XOR invert. When output enable is 0, the pin equals initial level XOR invert.
- R6: With clock select 0, the internal tick input advances the counter. With clock select 1, only rising edges on the external clock input advance it, one count per edge. Each edge passes through a two-flop synchronizer, and the internal tick input is ignored.
- R7: With buffer enable 0, compare reads and writes go straight to the working compare values.
- R8: With buffer enable 1, compare reads and writes go to a shadow copy. The shadow is copied into the working values on a software reset, and on a tick that reloads the counter from compare B.
- R9: In fine mode, the match for compare A uses A shifted right by one bit. When A bit 0 is 1, the rising edge of the active output is delayed until the next falling edge of the system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| tick_int | input | 1 | Internal count enable, one cycle per count |
| ext_clk | input | 1 | External count clock, asynchronous |
| pwm_out | output | 1 | Timer output pin |

## Verification
The main check sweeps every pair of compare A and compare B from 0 to 5, once with normal polarity and once inverted. Over two full periods it checks the pin and the counter against a closed-form expression for each cycle. This separates the normal case A < B from the A = B case, where B wins, and from the A > B case, where the output never turns active. It also shows up off-by-one errors in the period length.

Separate patterns cover other behaviour:
- Counting from external edges while the internal tick stays high shows that the unselected source is ignored.
- Clearing the run bit shows that the counter freezes.
- A shadow write made in the middle of a period shows that the period length changes only at the following wrap.
- An odd and an even fine-mode compare A, sampled before and after the falling clock edge, show the half-cycle delay.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_CMPA = 2'd1;
    localparam logic [1:0] ADR_CMPB = 2'd2;
    localparam logic [1:0] ADR_CNT  = 2'd3;

    localparam int CB_RUN  = 0;
    localparam int CB_RST  = 1;
    localparam int CB_OEN  = 2;
    localparam int CB_EXT  = 3;
    localparam int CB_INV  = 4;
    localparam int CB_BUF  = 5;
    localparam int CB_FINE = 6;
    localparam int CB_INIT = 8;

    typedef struct packed {
        logic run;
        logic oen;
        logic ext;
        logic inv;
        logic bufen;
        logic fine;
        logic init;
    } ctrl_t;
endpackage

// File: rtl/pwm_edge_sync.sv
module pwm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R6: one count per external edge
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pwm_counter_core.sv
module pwm_counter_core #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          sw_rst,
    input  logic          init_lvl,
    input  logic [CW-1:0] cmp_a,
    input  logic [CW-1:0] cmp_b,
    output logic [CW-1:0] cnt,
    output logic          active,
    output logic          wrap
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          act;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (sw_rst) begin
            st_d.cnt = '0;
            st_d.act = init_lvl;
        end else if (tick) begin
            if (st_q.cnt == cmp_b) begin
                st_d.cnt = '0;
                st_d.act = 1'b0;
                wrap     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == cmp_a) st_d.act = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign active = st_q.act;

    a_r2_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (cnt == '0));
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sw_rst && cnt == cmp_b) |=> (cnt == '0) && !active);
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sw_rst) |=> $stable(cnt) && $stable(active));
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic half_delay,
    input  logic oen,
    input  logic inv,
    input  logic init_lvl,
    output logic pin
);
    logic neg_d, neg_q;
    logic shaped;

    always_comb begin
        neg_d  = act;
        shaped = half_delay ? (act & neg_q) : act;
        pin    = (oen ? shaped : init_lvl) ^ inv;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= neg_d;
    end

    // R9: a delayed edge is still off-level in the half cycle it rises
    a_r9_half_delay: assert property (@(negedge clk) disable iff (!rst_n)
        (oen && half_delay && $rose(act)) |-> (pin == inv));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tick_int,
    input  logic          ext_clk,
    output logic          pwm_out
);
    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] cmp_a;
        logic [DW-1:0] cmp_b;
        logic [DW-1:0] sh_a;
        logic [DW-1:0] sh_b;
    } regs_t;

    regs_t r_d, r_q;

    logic          ext_rise;
    logic          tick;
    logic          sw_rst;
    logic          wr_ctrl;
    logic          load_shadow;
    logic          wrap;
    logic          act;
    logic [DW-1:0] cnt;
    logic [DW-1:0] cmp_a_eff;
    logic          init_next;

    pwm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_clk),
        .rise (ext_rise)
    );

    always_comb begin
        wr_ctrl   = bus_wr && (bus_addr == ADR_CTRL);
        sw_rst    = wr_ctrl && bus_wdata[CB_RST];
        init_next = wr_ctrl ? bus_wdata[CB_INIT] : r_q.ctrl.init;
        tick      = r_q.ctrl.run && (r_q.ctrl.ext ? ext_rise : tick_int);
        cmp_a_eff = r_q.ctrl.fine ? {1'b0, r_q.cmp_a[DW-1:1]} : r_q.cmp_a;
    end

    pwm_counter_core #(.CW(DW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .sw_rst  (sw_rst),
        .init_lvl(init_next),
        .cmp_a   (cmp_a_eff),
        .cmp_b   (r_q.cmp_b),
        .cnt     (cnt),
        .active  (act),
        .wrap    (wrap)
    );

    always_comb begin
        r_d = r_q;
        load_shadow = (sw_rst && bus_wdata[CB_BUF]) || (r_q.ctrl.bufen && wrap);
        if (load_shadow) begin
            r_d.cmp_a = r_q.sh_a;
            r_d.cmp_b = r_q.sh_b;
        end
        if (bus_wr) begin
            unique case (bus_addr)
                ADR_CTRL: begin
                    r_d.ctrl.run   = bus_wdata[CB_RUN];
                    r_d.ctrl.oen   = bus_wdata[CB_OEN];
                    r_d.ctrl.ext   = bus_wdata[CB_EXT];
                    r_d.ctrl.inv   = bus_wdata[CB_INV];
                    r_d.ctrl.bufen = bus_wdata[CB_BUF];
                    r_d.ctrl.fine  = bus_wdata[CB_FINE];
                    r_d.ctrl.init  = bus_wdata[CB_INIT];
                end
                ADR_CMPA: begin
                    if (r_q.ctrl.bufen) r_d.sh_a  = bus_wdata;
                    else                r_d.cmp_a = bus_wdata;
                end
                ADR_CMPB: begin
                    if (r_q.ctrl.bufen) r_d.sh_b  = bus_wdata;
                    else                r_d.cmp_b = bus_wdata;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CTRL: begin
                bus_rdata[CB_RUN]  = r_q.ctrl.run;
                bus_rdata[CB_OEN]  = r_q.ctrl.oen;
                bus_rdata[CB_EXT]  = r_q.ctrl.ext;
                bus_rdata[CB_INV]  = r_q.ctrl.inv;
                bus_rdata[CB_BUF]  = r_q.ctrl.bufen;
                bus_rdata[CB_FINE] = r_q.ctrl.fine;
                bus_rdata[CB_INIT] = r_q.ctrl.init;
            end
            ADR_CMPA: bus_rdata = r_q.ctrl.bufen ? r_q.sh_a : r_q.cmp_a;
            ADR_CMPB: bus_rdata = r_q.ctrl.bufen ? r_q.sh_b : r_q.cmp_b;
            default:  bus_rdata = cnt;
        endcase
    end

    pwm_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .half_delay(r_q.ctrl.fine && r_q.cmp_a[0]),
        .oen       (r_q.ctrl.oen),
        .inv       (r_q.ctrl.inv),
        .init_lvl  (r_q.ctrl.init),
        .pin       (pwm_out)
    );

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_CTRL) |-> (bus_rdata[CB_RST] == 1'b0)
            && (bus_rdata[7] == 1'b0) && (bus_rdata[DW-1:9] == '0));
    a_r6_source_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ctrl.run && r_q.ctrl.ext && !ext_rise && !sw_rst) |=> $stable(cnt));
    a_r8_wrap_load: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ctrl.bufen && wrap && !bus_wr) |=> (r_q.cmp_b == $past(r_q.sh_b)));
    a_r7_direct_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.ctrl.bufen && !bus_wr) |=> $stable(r_q.cmp_a) && $stable(r_q.cmp_b));
endmodule

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_int = 1'b1;
    logic        ext_clk = 1'b0;
    logic        pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    localparam logic [15:0] RUN = 16'h0001, RST = 16'h0002, OEN = 16'h0004,
                            EXT = 16'h0008, INV = 16'h0010, BUFE = 16'h0020,
                            FINE = 16'h0040, INIT = 16'h0100;

    pwm_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_int(tick_int),
        .ext_clk(ext_clk), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        step();

        // R1 reset state
        rd(0, v); check("R1 ctrl reset", v, 16'h0);
        rd(1, v); check("R1 cmpA reset", v, 16'h0);
        rd(2, v); check("R1 cmpB reset", v, 16'h0);
        rd(3, v); check("R1 cnt reset", v, 16'h0);
        check("R5 pin reset", {15'd0, pwm_out}, 16'h0);

        // R1 bit map, reserved and reset bit read 0
        wr(0, 16'hFFFF);
        rd(0, v); check("R1 ctrl readback", v, 16'h017D);
        wr(0, 16'h0000);

        // R7 direct compare access
        wr(1, 16'd9); rd(1, v); check("R7 direct cmpA", v, 16'd9);

        // R3/R4/R5 sweep
        for (int inv = 0; inv < 2; inv++) begin
            for (int a = 0; a < 6; a++) begin
                for (int b = 0; b < 6; b++) begin
                    wr(1, 16'(a));
                    wr(2, 16'(b));
                    wr(0, RUN | OEN | RST | (inv != 0 ? INV : 16'h0));
                    for (int k = 1; k <= 2 * (b + 1) + 2; k++) begin
                        int c;
                        logic e;
                        step();
                        c = (k - 1) % (b + 1);
                        e = (a < b) && (c >= a) && (c < b);
                        check("R4/R5 pin", {15'd0, pwm_out}, {15'd0, e ^ (inv != 0)});
                        rd(3, v);
                        check("R3 count", v, 16'(k % (b + 1)));
                    end
                end
            end
        end

        // R3 stop freezes, R2 writing reset bit 0 leaves count
        wr(1, 16'd50); wr(2, 16'd100);
        wr(0, RUN | OEN | RST);
        repeat (7) step();
        wr(0, OEN);
        rd(3, v); check("R2 rst-0 write keeps count", v, 16'd8);
        repeat (6) step();
        rd(3, v); check("R3 stopped count frozen", v, 16'd8);

        // R5 idle level with output disabled
        for (int m = 0; m < 4; m++) begin
            logic il, iv;
            il = m[0]; iv = m[1];
            wr(0, (il ? INIT : 16'h0) | (iv ? INV : 16'h0));
            check("R5 idle level", {15'd0, pwm_out}, {15'd0, il ^ iv});
        end
        // R2 software reset loads initial level
        wr(0, OEN | RST | INIT);
        check("R2 init load", {15'd0, pwm_out}, 16'd1);
        wr(0, OEN | RST | INIT | INV);
        check("R2 init load inverted", {15'd0, pwm_out}, 16'd0);

        // R6 external clock, internal tick held high and ignored
        wr(0, EXT | RUN | OEN | RST);
        for (int p = 0; p < 5; p++) begin
            ext_clk = 1'b1; repeat (3) step();
            ext_clk = 1'b0; repeat (3) step();
        end
        repeat (5) step();
        rd(3, v); check("R6 external edges counted", v, 16'd5);
        wr(0, EXT | OEN);
        ext_clk = 1'b1; repeat (4) step(); ext_clk = 1'b0; repeat (4) step();
        rd(3, v); check("R6 stopped ignores edges", v, 16'd5);

        // R8 buffered compares
        wr(0, BUFE);
        wr(1, 16'd1); wr(2, 16'd3);
        rd(2, v); check("R8 shadow read", v, 16'd3);
        wr(0, BUFE | RUN | OEN | RST);
        wr(2, 16'd6);
        rd(3, v); check("R8 count after load", v, 16'd1);
        repeat (3) step();
        rd(3, v); check("R8 old period wraps", v, 16'd0);
        repeat (4) step();
        rd(3, v); check("R8 new period length", v, 16'd4);
        rd(2, v); check("R8 shadow holds", v, 16'd6);

        // R9 fine mode
        wr(0, 16'h0);
        wr(1, 16'd3); wr(2, 16'd5);
        wr(0, FINE | RUN | OEN | RST);
        step(); step();
        check("R9 odd A before falling edge", {15'd0, pwm_out}, 16'd0);
        #10;
        check("R9 odd A after falling edge", {15'd0, pwm_out}, 16'd1);
        step();
        wr(0, 16'h0);
        wr(1, 16'd2);
        wr(0, FINE | RUN | OEN | RST);
        step(); step();
        check("R9 even A immediate", {15'd0, pwm_out}, 16'd1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule